// File: doc/BRIEF.md
# Doorbell-Driven Command Queue Sequencer

This block is the device-side engine for one pair of host-memory queues: a submission queue that holds 64-byte commands and a completion queue that takes 16-byte result entries. The host places commands in the submission queue and then writes the new tail index to a doorbell register. The sequencer then runs one command at a time. It fetches the command with a memory-read request and decodes it. For a read command it hands the starting block, the block count and the destination pointer to a data mover. It then writes a completion entry and pulses a message interrupt.

The block keeps its own submission head and completion tail. It learns the host's submission tail and completion head only through two doorbell writes. Both queues have the same power-of-two depth, and every index wraps modulo that depth. A completion is held back while the completion queue is full. It is released once the host reports, through the head doorbell, that it has consumed entries.

Top module: `cmdq_sequencer`

## Requirements
- R1: While reset is asserted and right after it, `mrd_req_valid`, `dm_req_valid`, `cpl_wr_valid` and `msi_pulse` are low. Both queue pointers start at 0 and the completion phase starts at 1.
- R2: A fetch is issued whenever the internal submission head differs from the doorbell tail. It is a single read request at `SQ_BASE + head*64` that returns 16 dwords, with dword k being bytes 4k..4k+3 of the command. A doorbell write that makes the tail equal to the head causes no fetch.
- R3: A command whose opcode (dword 0 bits 7:0) is 0x02 is a read. The data-mover request carries `dm_lba = {dword11, dword10}`, `dm_addr = {dword7, dword6}` and `dm_nblk = dword12[15:0] + 1`, because that field counts from zero.
- R4: Any other opcode skips the data phase and completes with status 0x01. A read completes with status 0.
- R5: For each command the order is fetch, then data transfer (reads only), then completion write, then interrupt. At most one of the fetch, data, completion and interrupt outputs is active in any cycle.
- R6: The completion entry goes to `CQ_BASE + tail*16`. Its dwords 0 and 1 are zero. Dword 2 holds the submission head after this command's fetch in bits 15:0, with bits 31:16 zero. Dword 3 holds the command identifier (dword 0 bits 31:16 of the command) in bits 15:0, the phase in bit 16, and the status in bits 31:17. Dword k sits at data bits 32k+31:32k.
- R7: The phase bit written in entries is 1 until the completion tail wraps from the last slot to slot 0. It inverts on every such wrap.
- R8: No completion is offered while the next completion tail would equal the host-written completion head. Posting resumes once a head doorbell write frees a slot.
- R9: `msi_pulse` is high for exactly one cycle, in the cycle after `cpl_wr_ack` is sampled high. `msi_vector` then equals `MSI_VEC`.
- R10: A doorbell write with `reg_wr_sel` = 0 sets the submission tail and one with `reg_wr_sel` = 1 sets the completion head, each to `reg_wr_data`. All pointers wrap modulo 2^`QDEPTH_LOG2`.
- R11: A data-mover or completion request that is not accepted stays valid with unchanged payload in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Doorbell write strobe |
| reg_wr_sel | input | 1 | 0 = submission tail, 1 = completion head |
| reg_wr_data | input | QDEPTH_LOG2 | Doorbell value |
| mrd_req_valid | output | 1 | Command fetch request |
| mrd_req_ready | input | 1 | Fetch request accepted |
| mrd_req_addr | output | 64 | Host address of the command slot |
| mrd_rsp_valid | input | 1 | Fetch data dword valid |
| mrd_rsp_data | input | 32 | Fetch data dword |
| dm_req_valid | output | 1 | Data-mover request |
| dm_req_ready | input | 1 | Data-mover request accepted |
| dm_lba | output | 64 | Starting logical block |
| dm_nblk | output | 17 | Number of blocks (one-based) |
| dm_addr | output | 64 | Host destination pointer |
| dm_done | input | 1 | Data transfer finished |
| cpl_wr_valid | output | 1 | Completion write request |
| cpl_wr_ready | input | 1 | Completion write accepted |
| cpl_wr_addr | output | 64 | Host address of the completion slot |
| cpl_wr_data | output | 128 | Completion entry |
| cpl_wr_ack | input | 1 | Completion write done |
| msi_pulse | output | 1 | Interrupt pulse |
| msi_vector | output | 8 | Interrupt vector |

## Verification
On every cycle the assertions check the following. No fetch is issued without a pending command. The four request outputs are mutually exclusive. No completion is offered into a full queue. The interrupt is a lone pulse that directly follows the write acknowledge. Stalled data and completion requests hold their payload. The phase inverts on each completion-queue wrap. Only the bench scenarios can show the rest, by comparing each fetch address, data request and completion entry with a behavioural model of the two queues: the decoded fields and the zero-based count, status for unknown opcodes, wrap of both indices, and resumption after the host frees completion slots.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef logic [15:0] qptr_t;
  typedef logic [63:0] addr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_REQ, ST_FETCH_DATA, ST_DM_REQ,
    ST_DM_WAIT, ST_CPL_REQ, ST_CPL_ACK, ST_IRQ
  } seq_state_e;

  localparam logic [7:0]  OPC_READ      = 8'h02;
  localparam logic [14:0] SC_OK         = 15'd0;
  localparam logic [14:0] SC_BAD_OPCODE = 15'd1;
  localparam int          SQE_SHIFT     = 6;   // 64-byte command slots
  localparam int          CQE_SHIFT     = 4;   // 16-byte completion slots

  // index increment modulo 2^lg
  function automatic qptr_t ptr_next(qptr_t p, int lg);
    qptr_t mask;
    mask = qptr_t'((32'd1 << lg) - 32'd1);
    return (p + 16'd1) & mask;
  endfunction

  function automatic addr_t slot_addr(addr_t base, qptr_t p, int sh);
    return base + (addr_t'(p) << sh);
  endfunction

  function automatic logic [16:0] blocks_of(logic [15:0] zero_based);
    return {1'b0, zero_based} + 17'd1;
  endfunction

  // dword3 | dword2 | dword1 | dword0
  function automatic logic [127:0] cpl_pack(qptr_t sq_head, logic [15:0] cid,
                                            logic phase, logic [14:0] sc);
    return {sc, phase, cid, 16'h0000, sq_head, 32'h0, 32'h0};
  endfunction
endpackage

// File: rtl/cmdq_doorbell_regs.sv
module cmdq_doorbell_regs #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  output logic [PTR_W-1:0] sq_tail,
  output logic [PTR_W-1:0] cq_head
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_tail <= '0;
      cq_head <= '0;
    end else if (wr_en) begin
      if (wr_sel) cq_head <= wr_data;
      else        sq_tail <= wr_data;
    end
  end
endmodule

// File: rtl/cmdq_cmd_capture.sv
module cmdq_cmd_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat_valid,
  input  logic [31:0] beat_data,
  output logic        beat_last,
  output logic [7:0]  opcode,
  output logic [15:0] cid,
  output logic [63:0] lba,
  output logic [63:0] prp,
  output logic [15:0] nlb_z
);
  logic [3:0] beat_cnt;

  assign beat_last = beat_valid && (beat_cnt == 4'd15);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      opcode   <= '0;
      cid      <= '0;
      lba      <= '0;
      prp      <= '0;
      nlb_z    <= '0;
    end else if (beat_valid) begin
      beat_cnt <= beat_cnt + 4'd1;
      case (beat_cnt)
        4'd0:  begin opcode <= beat_data[7:0]; cid <= beat_data[31:16]; end
        4'd6:  prp[31:0]  <= beat_data;
        4'd7:  prp[63:32] <= beat_data;
        4'd10: lba[31:0]  <= beat_data;
        4'd11: lba[63:32] <= beat_data;
        4'd12: nlb_z      <= beat_data[15:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_cq_tracker.sv
module cmdq_cq_tracker
  import cmdq_pkg::*;
#(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [PTR_W-1:0] cq_head,
  output logic [PTR_W-1:0] cq_tail,
  output logic             phase,
  output logic             full,
  output logic             wrap
);
  logic [PTR_W-1:0] tail_nxt;

  assign tail_nxt = PTR_W'(ptr_next(qptr_t'(cq_tail), PTR_W));
  assign full     = (tail_nxt == cq_head);
  assign wrap     = (cq_tail == {PTR_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cq_tail <= '0;
      phase   <= 1'b1;
    end else if (advance) begin
      cq_tail <= tail_nxt;
      if (wrap) phase <= ~phase;
    end
  end
endmodule

// File: rtl/cmdq_sequencer.sv
module cmdq_sequencer
  import cmdq_pkg::*;
#(
  parameter int          QDEPTH_LOG2 = 2,
  parameter logic [63:0] SQ_BASE     = 64'h0000_0000_1000_0000,
  parameter logic [63:0] CQ_BASE     = 64'h0000_0000_2000_0000,
  parameter logic [7:0]  MSI_VEC     = 8'd3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_en,
  input  logic                   reg_wr_sel,
  input  logic [QDEPTH_LOG2-1:0] reg_wr_data,
  output logic                   mrd_req_valid,
  input  logic                   mrd_req_ready,
  output logic [63:0]            mrd_req_addr,
  input  logic                   mrd_rsp_valid,
  input  logic [31:0]            mrd_rsp_data,
  output logic                   dm_req_valid,
  input  logic                   dm_req_ready,
  output logic [63:0]            dm_lba,
  output logic [16:0]            dm_nblk,
  output logic [63:0]            dm_addr,
  input  logic                   dm_done,
  output logic                   cpl_wr_valid,
  input  logic                   cpl_wr_ready,
  output logic [63:0]            cpl_wr_addr,
  output logic [127:0]           cpl_wr_data,
  input  logic                   cpl_wr_ack,
  output logic                   msi_pulse,
  output logic [7:0]             msi_vector
);
  localparam int PTR_W = QDEPTH_LOG2;

  seq_state_e       state, state_nxt;
  logic [PTR_W-1:0] sq_head, sq_tail, cq_head, cq_tail;
  logic             cq_phase, cq_full, cq_wrap, cq_adv;
  logic             fetch_pending, beat_valid, beat_last, is_read;
  logic [7:0]       opcode;
  logic [15:0]      cid, nlb_z;
  logic [63:0]      lba, prp;
  logic [14:0]      status;

  cmdq_doorbell_regs #(.PTR_W(PTR_W)) db_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .sq_tail(sq_tail), .cq_head(cq_head));

  cmdq_cmd_capture cap_i (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_data(mrd_rsp_data),
    .beat_last(beat_last), .opcode(opcode), .cid(cid), .lba(lba), .prp(prp),
    .nlb_z(nlb_z));

  cmdq_cq_tracker #(.PTR_W(PTR_W)) cq_i (
    .clk(clk), .rst_n(rst_n), .advance(cq_adv), .cq_head(cq_head),
    .cq_tail(cq_tail), .phase(cq_phase), .full(cq_full), .wrap(cq_wrap));

  assign fetch_pending = (sq_head != sq_tail);
  assign beat_valid    = mrd_rsp_valid && (state == ST_FETCH_DATA);
  assign is_read       = (opcode == OPC_READ);
  assign status        = is_read ? SC_OK : SC_BAD_OPCODE;
  assign cq_adv        = (state == ST_CPL_ACK) && cpl_wr_ack;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:       if (fetch_pending) state_nxt = ST_FETCH_REQ;
      ST_FETCH_REQ:  if (mrd_req_ready) state_nxt = ST_FETCH_DATA;
      ST_FETCH_DATA: if (beat_last) state_nxt = is_read ? ST_DM_REQ : ST_CPL_REQ;
      ST_DM_REQ:     if (dm_req_ready) state_nxt = ST_DM_WAIT;
      ST_DM_WAIT:    if (dm_done) state_nxt = ST_CPL_REQ;
      ST_CPL_REQ:    if (!cq_full && cpl_wr_ready) state_nxt = ST_CPL_ACK;
      ST_CPL_ACK:    if (cpl_wr_ack) state_nxt = ST_IRQ;
      ST_IRQ:        state_nxt = ST_IDLE;
      default:       state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sq_head <= '0;
    end else begin
      state <= state_nxt;
      if (beat_last) sq_head <= PTR_W'(ptr_next(qptr_t'(sq_head), PTR_W));
    end
  end

  assign mrd_req_valid = (state == ST_FETCH_REQ);
  assign mrd_req_addr  = slot_addr(SQ_BASE, qptr_t'(sq_head), SQE_SHIFT);
  assign dm_req_valid  = (state == ST_DM_REQ);
  assign dm_lba        = lba;
  assign dm_addr       = prp;
  assign dm_nblk       = blocks_of(nlb_z);
  assign cpl_wr_valid  = (state == ST_CPL_REQ) && !cq_full;
  assign cpl_wr_addr   = slot_addr(CQ_BASE, qptr_t'(cq_tail), CQE_SHIFT);
  assign cpl_wr_data   = cpl_pack(qptr_t'(sq_head), cid, cq_phase, status);
  assign msi_pulse     = (state == ST_IRQ);
  assign msi_vector    = MSI_VEC;
endmodule

// File: rtl/cmdq_sequencer_chk.sv
module cmdq_sequencer_chk #(
  parameter int PTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrd_req_valid,
  input logic             dm_req_valid,
  input logic             dm_req_ready,
  input logic [63:0]      dm_lba,
  input logic [16:0]      dm_nblk,
  input logic [63:0]      dm_addr,
  input logic             cpl_wr_valid,
  input logic             cpl_wr_ready,
  input logic [127:0]     cpl_wr_data,
  input logic             cpl_wr_ack,
  input logic             msi_pulse,
  input logic [PTR_W-1:0] sq_head_w,
  input logic [PTR_W-1:0] sq_tail_w,
  input logic             cq_full_w,
  input logic             cq_wrap_w,
  input logic             cq_adv_w,
  input logic             cq_phase_w
);
  // R2
  fetch_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req_valid |-> (sq_head_w != sq_tail_w));

  // R5
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mrd_req_valid, dm_req_valid, cpl_wr_valid, msi_pulse}));

  // R8
  cq_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_wr_valid |-> !cq_full_w);

  // R9
  msi_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> $past(cpl_wr_ack));

  // R9
  msi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |=> !msi_pulse);

  // R11
  dm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req_valid && !dm_req_ready) |=>
      (dm_req_valid && $stable(dm_lba) && $stable(dm_nblk) && $stable(dm_addr)));

  // R11
  cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_wr_valid && !cpl_wr_ready) |=> (cpl_wr_valid && $stable(cpl_wr_data)));

  // R7
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_adv_w && cq_wrap_w) |=> (cq_phase_w != $past(cq_phase_w)));
endmodule

bind cmdq_sequencer cmdq_sequencer_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mrd_req_valid(mrd_req_valid),
  .dm_req_valid(dm_req_valid), .dm_req_ready(dm_req_ready), .dm_lba(dm_lba),
  .dm_nblk(dm_nblk), .dm_addr(dm_addr), .cpl_wr_valid(cpl_wr_valid),
  .cpl_wr_ready(cpl_wr_ready), .cpl_wr_data(cpl_wr_data), .cpl_wr_ack(cpl_wr_ack),
  .msi_pulse(msi_pulse), .sq_head_w(sq_head), .sq_tail_w(sq_tail),
  .cq_full_w(cq_full), .cq_wrap_w(cq_wrap), .cq_adv_w(cq_adv),
  .cq_phase_w(cq_phase));

// File: tb/cmdq_sequencer_tb_top.sv
`timescale 1ns/1ps
module cmdq_sequencer_tb_top;
  localparam logic [63:0] SQB = 64'h0000_0000_1000_0000;
  localparam logic [63:0] CQB = 64'h0000_0000_2000_0000;
  localparam int DEPTH = 4;

  typedef struct {
    logic [7:0]  opc;
    logic [15:0] cid;
    logic [63:0] lba;
    logic [15:0] nlb;
    logic [63:0] prp;
  } cmd_t;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, reg_wr_sel = 0;
  logic [1:0] reg_wr_data = 0;
  logic mrd_req_valid, mrd_req_ready, mrd_rsp_valid = 0;
  logic [63:0] mrd_req_addr;
  logic [31:0] mrd_rsp_data = 0;
  logic dm_req_valid, dm_req_ready = 0, dm_done = 0;
  logic [63:0] dm_lba, dm_addr;
  logic [16:0] dm_nblk;
  logic cpl_wr_valid, cpl_wr_ready = 0, cpl_wr_ack = 0;
  logic [63:0] cpl_wr_addr;
  logic [127:0] cpl_wr_data;
  logic msi_pulse;
  logic [7:0] msi_vector;

  always #2.5 clk = ~clk;

  assign mrd_req_ready = 1'b1;

  cmdq_sequencer dut_i (.*);

  // host memory and host-side state
  logic [31:0] sqmem [0:DEPTH*16-1];
  cmd_t cmd_tab [0:DEPTH-1];
  int host_sq_tail = 0, host_cq_head = 0;
  bit dm_slow = 0, cpl_slow = 0;

  // counters: main process and model process kept separate
  int chk_s = 0, err_s = 0, chk_m = 0, err_m = 0;
  int n_fetch = 0, n_cpl = 0, n_msi = 0;

  task automatic check_s(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
    chk_s++;
    if (!ok) begin
      err_s++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_m(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
    chk_m++;
    if (!ok) begin
      err_m++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // fetch responder: 16 dwords, one per cycle, after the request handshake
  int rsp_cnt = 0, rsp_slot = 0;
  initial forever begin
    @(posedge clk);
    if (rsp_cnt > 0) begin
      mrd_rsp_valid <= 1'b1;
      mrd_rsp_data  <= sqmem[rsp_slot*16 + (16 - rsp_cnt)];
      rsp_cnt--;
    end else begin
      mrd_rsp_valid <= 1'b0;
    end
    if (mrd_req_valid && mrd_req_ready && rsp_cnt == 0) begin
      rsp_slot = int'((mrd_req_addr - SQB) >> 6) % DEPTH;
      rsp_cnt  = 16;
    end
  end

  // data mover: optional ready throttling, done three cycles after accept
  int dm_cyc = 0, dm_cnt = 0;
  initial forever begin
    @(posedge clk);
    dm_cyc++;
    dm_req_ready <= dm_slow ? (dm_cyc % 3 == 0) : 1'b1;
    if (dm_cnt > 0) begin
      dm_cnt--;
      dm_done <= (dm_cnt == 0);
    end else dm_done <= 1'b0;
    if (dm_req_valid && dm_req_ready) dm_cnt = 3;
  end

  // completion sink: optional ready throttling, ack two cycles after accept
  int cp_cyc = 0, ack_cnt = 0;
  initial forever begin
    @(posedge clk);
    cp_cyc++;
    cpl_wr_ready <= cpl_slow ? (cp_cyc % 2 == 0) : 1'b1;
    if (ack_cnt > 0) begin
      ack_cnt--;
      cpl_wr_ack <= (ack_cnt == 0);
    end else cpl_wr_ack <= 1'b0;
    if (cpl_wr_valid && cpl_wr_ready) ack_cnt = 2;
  end

  // behavioural reference model, compared on every clock at the falling edge
  int m_sq_head = 0, m_cq_tail = 0, cur_head = 0;
  bit m_phase = 1, cur_dm = 0, ack_prev = 0;
  cmd_t cur;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      automatic int used = (m_cq_tail - host_cq_head + DEPTH) % DEPTH;
      check_m(($countones({mrd_req_valid, dm_req_valid, cpl_wr_valid, msi_pulse}) <= 1),
              "R5 exclusive requests", {mrd_req_valid, dm_req_valid, cpl_wr_valid, msi_pulse}, 0);
      if (mrd_req_valid && mrd_req_ready) begin
        check_m(m_sq_head != host_sq_tail, "R2 fetch only when pending", m_sq_head, host_sq_tail);
        check_m(mrd_req_addr == SQB + 64'(m_sq_head) * 64, "R2 fetch address",
                mrd_req_addr, SQB + 64'(m_sq_head) * 64);
        cur = cmd_tab[m_sq_head];
        m_sq_head = (m_sq_head + 1) % DEPTH;
        cur_head = m_sq_head;
        cur_dm = 0;
        n_fetch++;
      end
      if (dm_req_valid && dm_req_ready) begin
        check_m(cur.opc == 8'h02, "R4 no data phase for non-read", cur.opc, 8'h02);
        check_m(dm_lba == cur.lba, "R3 start block", dm_lba, cur.lba);
        check_m(dm_addr == cur.prp, "R3 data pointer", dm_addr, cur.prp);
        check_m(dm_nblk == 17'(cur.nlb) + 17'd1, "R3 one-based block count",
                dm_nblk, 17'(cur.nlb) + 17'd1);
        cur_dm = 1;
      end
      if (cpl_wr_valid)
        check_m(used < DEPTH - 1, "R8 completion offered only with space", used, DEPTH - 1);
      if (cpl_wr_valid && cpl_wr_ready) begin
        automatic logic [14:0] sc = (cur.opc == 8'h02) ? 15'd0 : 15'd1;
        automatic logic [127:0] exp_e = {sc, m_phase, cur.cid, 16'h0, 16'(cur_head), 64'h0};
        check_m(cpl_wr_addr == CQB + 64'(m_cq_tail) * 16, "R6 completion address",
                cpl_wr_addr, CQB + 64'(m_cq_tail) * 16);
        check_m(cpl_wr_data == exp_e, "R6 R4 completion entry", cpl_wr_data, exp_e);
        check_m(cpl_wr_data[112] == m_phase, "R7 phase bit", cpl_wr_data[112], m_phase);
        check_m(cur.opc != 8'h02 || cur_dm, "R5 data before completion", cur_dm, 1);
        if (m_cq_tail == DEPTH - 1) m_phase = ~m_phase;
        m_cq_tail = (m_cq_tail + 1) % DEPTH;
        n_cpl++;
      end
      if (ack_prev || msi_pulse) begin
        check_m(msi_pulse == ack_prev, "R9 interrupt follows ack", msi_pulse, ack_prev);
        if (msi_pulse) begin
          check_m(msi_vector == 8'd3, "R9 vector", msi_vector, 8'd3);
          n_msi++;
        end
      end
      ack_prev = cpl_wr_ack;
    end
  end

  task automatic put_cmd(input int slot, input logic [7:0] opc, input logic [15:0] cid,
                         input logic [63:0] lba, input logic [15:0] nlb,
                         input logic [63:0] prp);
    for (int i = 0; i < 16; i++) sqmem[slot*16 + i] = 32'hA5A5_0000 + i;
    sqmem[slot*16 + 0]  = {cid, 8'h00, opc};
    sqmem[slot*16 + 6]  = prp[31:0];
    sqmem[slot*16 + 7]  = prp[63:32];
    sqmem[slot*16 + 10] = lba[31:0];
    sqmem[slot*16 + 11] = lba[63:32];
    sqmem[slot*16 + 12] = {16'hFFFF, nlb};
    cmd_tab[slot] = '{opc, cid, lba, nlb, prp};
  endtask

  task automatic db_write(input bit sel, input int val);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = 2'(val);
    if (sel) host_cq_head = val; else host_sq_tail = val;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic wait_cpl(input int n);
    int t = 0;
    while (n_cpl < n && t < 3000) begin @(negedge clk); t++; end
    check_s(n_cpl == n, "R5 R10 completions reached", n_cpl, n);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run(input int extra);
    $display("CHECKS %0d ERRORS %0d", chk_s + chk_m + extra, err_s + err_m + extra);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run(1);
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 outputs idle during and after reset
    check_s({mrd_req_valid, dm_req_valid, cpl_wr_valid, msi_pulse} == 4'b0,
            "R1 idle in reset", {mrd_req_valid, dm_req_valid, cpl_wr_valid, msi_pulse}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_s({mrd_req_valid, dm_req_valid, cpl_wr_valid, msi_pulse} == 4'b0,
            "R1 idle after reset", {mrd_req_valid, dm_req_valid, cpl_wr_valid, msi_pulse}, 0);

    // R2 tail equal to head: nothing happens
    db_write(0, 0);
    repeat (20) @(negedge clk);
    check_s(n_fetch == 0, "R2 equal tail ignored", n_fetch, 0);

    // single read: 4 KiB at 512-byte blocks, zero-based count 7
    put_cmd(0, 8'h02, 16'h0101, 64'h8, 16'd7, 64'hFEB8_4000);
    db_write(0, 1);
    wait_cpl(1);
    db_write(1, 1);

    // R4 unknown opcode then a read, with throttled data mover and sink (R11)
    dm_slow = 1; cpl_slow = 1;
    put_cmd(1, 8'h09, 16'h0222, 64'h0, 16'd0, 64'h0);
    put_cmd(2, 8'h02, 16'h0333, 64'h1_2345_6789, 16'hFFFF, 64'h1_0000_2000);
    db_write(0, 3);
    wait_cpl(3);
    db_write(1, 3);
    dm_slow = 0; cpl_slow = 0;

    // R10 index wrap on both queues, R7 phase inversion
    put_cmd(3, 8'h02, 16'h0444, 64'h100, 16'd1, 64'hA000);
    put_cmd(0, 8'h02, 16'h0555, 64'h200, 16'd2, 64'hB000);
    put_cmd(1, 8'h02, 16'h0666, 64'h300, 16'd3, 64'hC000);
    db_write(0, 0);
    db_write(0, 2);
    wait_cpl(6);

    // R8 queue now full: next completion must wait for the head doorbell
    put_cmd(2, 8'h02, 16'h0777, 64'h400, 16'd4, 64'hD000);
    put_cmd(3, 8'h11, 16'h0888, 64'h0, 16'd0, 64'h0);
    db_write(0, 0);
    repeat (60) @(negedge clk);
    check_s(n_cpl == 6, "R8 completion held while full", n_cpl, 6);
    check_s(n_fetch == 7, "R8 fetch of stalled command done", n_fetch, 7);
    db_write(1, 2);
    wait_cpl(8);
    check_s(n_fetch == 8, "R2 every pending command fetched", n_fetch, 8);
    check_s(n_msi == 8, "R9 one interrupt per completion", n_msi, 8);
    check_s(m_phase == 1'b1, "R7 phase after two wraps", m_phase, 1);

    // R2 repeated tail write with no new work
    db_write(0, 0);
    repeat (20) @(negedge clk);
    check_s(n_fetch == 8, "R2 repeated tail ignored", n_fetch, 8);
    finish_run(0);
  end
endmodule